// File: doc/BRIEF.md
# Fractional Baud Tick Generator with Line Format Decode

This block derives the 16x oversampling strobe that a UART serializer and deserializer use, starting from a fixed reference clock. A 16-bit integer divisor and a 3-bit fraction set the bit time. Each bit lasts exactly `16*divisor + 16 + fraction` reference cycles, which is the reference rate divided by the baud rate. The integer part sets the length of every one of the 16 sub-ticks, which is `divisor + 1` cycles. The fraction adds one extra cycle to each of the first `fraction` sub-ticks of every bit. A divisor of zero is not a usable setting, so the generator stays idle while it holds.

The same write port also accepts the line control byte. The block decodes that byte into a word length, a stop-bit count, a parity mode and an infrared flag for the shift logic next to it. Any write to the line, divisor or fraction register recomputes the decoded format. The recomputation only takes effect when the divisor that results from the write is nonzero. Writing the divisor also restarts the sub-tick sequence at the first sub-tick of a fresh bit.

Top module: `baud_frac_gen`

## Requirements
- R1: After reset, os_tick, bit_tick and gen_run are low, and the format outputs show 5 data bits, one stop bit, parity off and infrared off.
- R2: While the divisor register holds 0, gen_run is low and os_tick and bit_tick stay low. Writing 0 to the divisor drops gen_run on the next cycle.
- R3: While running with divisor D and fraction F, sub-tick i of a bit (i = 0..15) lasts D+1 reference cycles, plus one more when i < F. os_tick is high for one cycle at the end of each sub-tick. Only wr_data[2:0] of a fraction write is kept.
- R4: bit_tick is high together with os_tick on the 16th sub-tick of each bit. When the fraction is not rewritten in between, consecutive bit_ticks are 16*D+16+F cycles apart.
- R5: A write to the divisor (wr_sel = 1) restarts at sub-tick 0 with an empty count. Counting the cycle after the write edge as cycle 0, the first os_tick falls in cycle D + (F>0 ? 1 : 0).
- R6: data_bits equals line bits [1:0] plus 5.
- R7: two_stop follows line bit 2.
- R8: parity_en follows line bit 5. parity_even follows line bit 3 when bit 5 is set, and is 0 when parity is off.
- R9: ir_mode follows line bit 6.
- R10: A write with wr_sel 0 (line), 1 (divisor) or 2 (fraction) reloads the format outputs from the last line value written, one cycle after the write. This happens only if the divisor after that write is nonzero. Otherwise the previous format is kept.
- R11: A write with wr_sel = 3 changes nothing: the format outputs and the tick sequence go on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 line control, 1 divisor, 2 fraction, 3 none |
| wr_data | input | 16 | Write data |
| gen_run | output | 1 | Divisor is nonzero and ticks are produced |
| os_tick | output | 1 | One-cycle 16x oversampling strobe |
| bit_tick | output | 1 | Strobe on the last sub-tick of each bit |
| data_bits | output | 4 | Decoded word length, 5 to 8 |
| two_stop | output | 1 | Two stop bits selected |
| parity_en | output | 1 | Parity bit present |
| parity_even | output | 1 | Even parity selected |
| ir_mode | output | 1 | Infrared framing selected |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor, a 3-bit fraction, 16 sub-ticks per bit and infrared decode enabled. It uses divisors of 1 to 3, so each bit takes only 32 to 71 cycles. That keeps many complete bit periods, stretched and unstretched sub-ticks, and fraction values 0, 3, 5 and 7 within a short run. Fraction changes in the middle of a bit are covered, as are divisor restarts in the middle of a bit, an idle spell with a line write that must not take effect, and a write with the unused selector.

// File: rtl/baud_pkg.sv
package baud_pkg;

   // write targets on the configuration port
   typedef enum logic [1:0] {
      SEL_LINE = 2'd0,
      SEL_DIV  = 2'd1,
      SEL_FRAC = 2'd2,
      SEL_NONE = 2'd3
   } wr_sel_e;

   // bit positions in the line control byte that the shifter depends on
   localparam int LB_WLEN_LO = 0;
   localparam int LB_STOP    = 2;
   localparam int LB_EVEN    = 3;
   localparam int LB_PAR     = 5;
   localparam int LB_IR      = 6;
   // compacted line field: {ir, par, even, stop, wlen[1:0]}
   localparam int LINE_W     = 6;

   typedef struct packed {
      logic [3:0] data_bits;
      logic       two_stop;
      logic       parity_en;
      logic       parity_even;
      logic       ir_mode;
   } line_fmt_t;

   localparam line_fmt_t FMT_RESET = '{data_bits: 4'd5, two_stop: 1'b0,
                                       parity_en: 1'b0, parity_even: 1'b0,
                                       ir_mode: 1'b0};

endpackage

// File: rtl/baud_fmt_decode.sv
module baud_fmt_decode
   import baud_pkg::*;
#(
   parameter bit IR_EN = 1'b1
) (
   input  logic [LINE_W-1:0] line_i,
   output line_fmt_t         fmt_o
);

   // line_i layout: [5] ir, [4] parity on, [3] even, [2] stop, [1:0] wlen
   logic ir_bit;

   generate
      if (IR_EN) begin : g_ir
         assign ir_bit = line_i[5];
      end else begin : g_no_ir
         assign ir_bit = 1'b0;
      end
   endgenerate

   always_comb begin
      fmt_o.data_bits   = {2'b00, line_i[1:0]} + 4'd5;
      fmt_o.two_stop    = line_i[2];
      fmt_o.parity_en   = line_i[4];
      fmt_o.parity_even = line_i[4] & line_i[3];
      fmt_o.ir_mode     = ir_bit;
   end

endmodule

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
   import baud_pkg::*;
#(
   parameter int DIV_W  = 16,
   parameter int FRAC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [DIV_W-1:0] wr_data,
   input  line_fmt_t        line_dec_i,
   output logic [DIV_W-1:0] div_o,
   output logic [FRAC_W-1:0] frac_o,
   output line_fmt_t        fmt_o,
   output logic             restart_o
);

   logic [DIV_W-1:0]  div_q,  div_d;
   logic [FRAC_W-1:0] frac_q, frac_d;
   line_fmt_t         pend_q, pend_d;
   line_fmt_t         fmt_q;
   logic              hit_line, hit_div, hit_frac, fmt_load;

   always_comb begin
      hit_line = wr_en && (wr_sel == SEL_LINE);
      hit_div  = wr_en && (wr_sel == SEL_DIV);
      hit_frac = wr_en && (wr_sel == SEL_FRAC);
      div_d    = hit_div  ? wr_data              : div_q;
      frac_d   = hit_frac ? wr_data[FRAC_W-1:0]  : frac_q;
      pend_d   = hit_line ? line_dec_i           : pend_q;
      fmt_load = (hit_line || hit_div || hit_frac) && (div_d != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         frac_q <= '0;
         pend_q <= FMT_RESET;
         fmt_q  <= FMT_RESET;
      end else begin
         div_q  <= div_d;
         frac_q <= frac_d;
         pend_q <= pend_d;
         if (fmt_load) begin
            fmt_q <= pend_d;
         end
      end
   end

   assign div_o     = div_q;
   assign frac_o    = frac_q;
   assign fmt_o     = fmt_q;
   assign restart_o = hit_div;

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
   parameter int DIV_W    = 16,
   parameter int FRAC_W   = 3,
   parameter int OSR_LOG2 = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic [FRAC_W-1:0] frac_i,
   output logic              run_o,
   output logic              os_tick_o,
   output logic              bit_tick_o
);

   localparam int CNT_W = DIV_W + 1;
   localparam int CMP_W = (OSR_LOG2 > FRAC_W) ? OSR_LOG2 : FRAC_W;
   localparam logic [OSR_LOG2-1:0] SUB_LAST = {OSR_LOG2{1'b1}};

   logic [CNT_W-1:0]    cnt_q;
   logic [OSR_LOG2-1:0] sub_q;
   logic                stretch;
   logic [CNT_W-1:0]    cnt_last;
   logic                tick;

   // one spare cycle for each of the first frac_i sub-ticks of a bit
   always_comb begin
      stretch  = CMP_W'(sub_q) < CMP_W'(frac_i);
      cnt_last = CNT_W'(div_i) + CNT_W'(stretch);
      run_o    = (div_i != '0);
      tick     = run_o && (cnt_q == cnt_last);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sub_q <= '0;
      end else if (restart_i || !run_o) begin
         cnt_q <= '0;
         sub_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
         sub_q <= sub_q + 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign os_tick_o  = tick;
   assign bit_tick_o = tick && (sub_q == SUB_LAST);

endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen
   import baud_pkg::*;
#(
   parameter int DIV_W    = 16,
   parameter int FRAC_W   = 3,
   parameter int OSR_LOG2 = 4,
   parameter bit IR_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [DIV_W-1:0] wr_data,
   output logic             gen_run,
   output logic             os_tick,
   output logic             bit_tick,
   output logic [3:0]       data_bits,
   output logic             two_stop,
   output logic             parity_en,
   output logic             parity_even,
   output logic             ir_mode
);

   // elaboration-time parameter checks
   generate
      if (FRAC_W < 1 || FRAC_W > OSR_LOG2) begin : g_bad_frac
         $error("FRAC_W must be between 1 and OSR_LOG2");
      end
      if (DIV_W <= LB_IR) begin : g_bad_div
         $error("DIV_W too narrow to carry the line control byte");
      end
      if (OSR_LOG2 < 1) begin : g_bad_osr
         $error("OSR_LOG2 must be at least 1");
      end
   endgenerate

   logic [LINE_W-1:0]  line_bits;
   line_fmt_t          line_dec;
   line_fmt_t          fmt;
   logic [DIV_W-1:0]   div_val;
   logic [FRAC_W-1:0]  frac_val;
   logic               restart;

   assign line_bits = {wr_data[LB_IR], wr_data[LB_PAR], wr_data[LB_EVEN],
                       wr_data[LB_STOP], wr_data[LB_WLEN_LO+1:LB_WLEN_LO]};

   baud_fmt_decode #(.IR_EN(IR_EN)) u_dec (
      .line_i (line_bits),
      .fmt_o  (line_dec)
   );

   baud_cfg_regs #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .line_dec_i (line_dec),
      .div_o      (div_val),
      .frac_o     (frac_val),
      .fmt_o      (fmt),
      .restart_o  (restart)
   );

   baud_tick_gen #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .OSR_LOG2(OSR_LOG2)) u_tick (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart_i  (restart),
      .div_i      (div_val),
      .frac_i     (frac_val),
      .run_o      (gen_run),
      .os_tick_o  (os_tick),
      .bit_tick_o (bit_tick)
   );

   assign data_bits   = fmt.data_bits;
   assign two_stop    = fmt.two_stop;
   assign parity_en   = fmt.parity_en;
   assign parity_even = fmt.parity_even;
   assign ir_mode     = fmt.ir_mode;

endmodule

// File: rtl/baud_frac_chk.sv
module baud_frac_chk #(
   parameter int DIV_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_sel,
   input logic [DIV_W-1:0] wr_data,
   input logic             gen_run,
   input logic             os_tick,
   input logic             bit_tick,
   input logic [3:0]       data_bits,
   input logic             two_stop,
   input logic             parity_en,
   input logic             parity_even,
   input logic             ir_mode
);

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_run |-> (!os_tick && !bit_tick));

   assert_zero_div_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1 && wr_data == '0) |=> !gen_run);

   assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      os_tick |=> !os_tick);

   assert_bit_on_subtick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> os_tick);

   assert_restart_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1 && wr_data != '0) |=> (gen_run && !os_tick));

   assert_fmt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_sel == 2'd3) |=>
         $stable({data_bits, two_stop, parity_en, parity_even, ir_mode}));

   assert_word_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_bits >= 4'd5) && (data_bits <= 4'd8));

   assert_even_needs_par_R8: assert property (@(posedge clk) disable iff (!rst_n)
      parity_even |-> parity_en);

endmodule

bind baud_frac_gen baud_frac_chk #(.DIV_W(DIV_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_sel      (wr_sel),
   .wr_data     (wr_data),
   .gen_run     (gen_run),
   .os_tick     (os_tick),
   .bit_tick    (bit_tick),
   .data_bits   (data_bits),
   .two_stop    (two_stop),
   .parity_en   (parity_en),
   .parity_even (parity_even),
   .ir_mode     (ir_mode)
);

// File: tb/baud_frac_gen_bench.sv
`timescale 1ns/1ps
module baud_frac_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd3;
   logic [15:0] wr_data = '0;
   logic        gen_run, os_tick, bit_tick;
   logic [3:0]  data_bits;
   logic        two_stop, parity_en, parity_even, ir_mode;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   baud_frac_gen u_baud_frac_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .gen_run(gen_run), .os_tick(os_tick), .bit_tick(bit_tick),
      .data_bits(data_bits), .two_stop(two_stop), .parity_en(parity_en),
      .parity_even(parity_even), .ir_mode(ir_mode)
   );

   // behavioural reference state
   int m_div = 0, m_frac = 0, m_sub = 0, m_el = 0;
   int p_bits = 5, p_stop = 0, p_par = 0, p_even = 0, p_ir = 0; // last line written
   int e_bits = 5, e_stop = 0, e_par = 0, e_even = 0, e_ir = 0; // expected outputs
   int since = 0;
   bit dirty = 1'b0;
   bit model_on = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit exp_tick();
      return (m_div != 0) && (m_el == m_div + ((m_sub < m_frac) ? 1 : 0));
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_div = 0; m_frac = 0; m_sub = 0; m_el = 0; since = 0; dirty = 1'b0;
         p_bits = 5; p_stop = 0; p_par = 0; p_even = 0; p_ir = 0;
         e_bits = 5; e_stop = 0; e_par = 0; e_even = 0; e_ir = 0;
      end else begin
         automatic bit t = exp_tick();
         automatic int nd = m_div;
         automatic int nf = m_frac;
         automatic bit wdiv = wr_en && wr_sel == 2'd1;
         if (wr_en && wr_sel == 2'd0) begin
            p_bits = int'(wr_data[1:0]) + 5;
            p_stop = wr_data[2];
            p_par  = wr_data[5];
            p_even = wr_data[5] & wr_data[3];
            p_ir   = wr_data[6];
         end
         if (wdiv) nd = wr_data;
         if (wr_en && wr_sel == 2'd2) nf = wr_data & 7;
         if (wdiv || m_div == 0) begin
            m_el = 0; m_sub = 0; since = 0; dirty = 1'b0;
         end else if (t) begin
            if (m_sub == 15) begin since = 0; dirty = 1'b0; end
            else since++;
            m_el = 0; m_sub = (m_sub + 1) % 16;
         end else begin
            m_el++; since++;
         end
         if (wr_en && wr_sel == 2'd2) dirty = 1'b1;
         if (wr_en && wr_sel != 2'd3 && nd != 0) begin
            e_bits = p_bits; e_stop = p_stop; e_par = p_par; e_even = p_even; e_ir = p_ir;
         end
         m_div = nd; m_frac = nf;
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (model_on) begin
         automatic bit t = exp_tick();
         check(os_tick == t, "R3 os_tick", os_tick, t);
         check(bit_tick == (t && m_sub == 15), "R4 bit_tick", bit_tick, t && m_sub == 15);
         check(gen_run == (m_div != 0), "R2 gen_run", gen_run, m_div != 0);
         check(data_bits == e_bits, "R6 data_bits", data_bits, e_bits);
         check(two_stop == e_stop, "R7 two_stop", two_stop, e_stop);
         check(parity_en == e_par && parity_even == e_even, "R8 parity",
               {parity_en, parity_even}, {e_par[0], e_even[0]});
         check(ir_mode == e_ir, "R9 ir_mode", ir_mode, e_ir);
         if (bit_tick && !dirty)
            check(since == 16 * m_div + 16 + m_frac - 1, "R4 bit period",
                  since + 1, 16 * m_div + 16 + m_frac);
      end
   end

   task automatic wr(input logic [1:0] sel, input logic [15:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
   endtask

   // after a divisor write: cycles from the write edge to the first tick
   task automatic restart_check(input int d, input int f);
      int n = 0;
      wr(2'd1, 16'(d));
      while (!os_tick && n < 1000) begin
         @(negedge clk);
         n++;
      end
      check(n == d + ((f > 0) ? 1 : 0), "R5 first tick", n, d + ((f > 0) ? 1 : 0));
   endtask

   task automatic idle_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!os_tick && !bit_tick && !gen_run, "R1 strobes", {os_tick, bit_tick, gen_run}, 0);
      check(data_bits == 4'd5 && !two_stop && !parity_en && !parity_even && !ir_mode,
            "R1 format", data_bits, 5);
      model_on = 1'b1;

      // configure while idle: format must hold (R10)
      wr(2'd2, 16'd3);
      wr(2'd0, 16'h002B);
      idle_cycles(2);
      check(data_bits == 4'd5 && !parity_en, "R10 idle hold", data_bits, 5);
      idle_cycles(20);

      // start: D=2, F=3, bit = 51 cycles
      restart_check(2, 3);
      check(data_bits == 4'd8 && parity_en && parity_even, "R10 load on div", data_bits, 8);
      idle_cycles(160);

      // fraction change mid-run, upper bits ignored (R3): 0x0D -> 5
      wr(2'd2, 16'h000D);
      idle_cycles(170);

      // line rewrite while running: 8 bits, two stop, no parity, infrared
      wr(2'd0, 16'h0047);
      @(negedge clk);
      check(ir_mode && two_stop && !parity_en && data_bits == 4'd8, "R9 line load",
            {ir_mode, two_stop, parity_en}, 3'b110);
      idle_cycles(60);

      // unused selector ignored (R11)
      wr(2'd3, 16'hFFFF);
      check(ir_mode && two_stop && data_bits == 4'd8, "R11 no effect", data_bits, 8);
      idle_cycles(120);

      // restart mid-bit with D=1, F=5
      idle_cycles(7);
      restart_check(1, 5);
      idle_cycles(140);

      // divisor zero: idle, later line write held (R2, R10)
      wr(2'd1, 16'd0);
      check(!gen_run, "R2 stop", gen_run, 0);
      wr(2'd0, 16'h0001);
      idle_cycles(3);
      check(data_bits == 4'd8 && ir_mode, "R10 hold while idle", data_bits, 8);
      wr(2'd2, 16'd7);
      idle_cycles(30);

      // D=3, F=7: picks up the held line byte (6 bits, no parity)
      restart_check(3, 7);
      check(data_bits == 4'd6 && !ir_mode && !two_stop && !parity_en, "R6 held line",
            data_bits, 6);
      idle_cycles(220);

      // F=0 on D=1: 32-cycle bits
      wr(2'd2, 16'd0);
      restart_check(1, 0);
      idle_cycles(100);

      model_on = 1'b0;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule